// File: doc/BRIEF.md
# Atomic Masked Bit-Manipulation Unit

This unit performs one indivisible read-modify-write on a 16-bit target word, steered by a 16-bit immediate mask. The target can be a core register, a peripheral register or a data memory word; the unit does not care which, because it only sees a read port and a write port. Four operations are offered: test, set, clear and invert of the bits the mask selects. The whole sequence fits in the cycle in which the request is presented: the read is issued, the returned word is modified, and the write is issued before the next clock edge. For that whole cycle a lock output tells the bus fabric and the interrupt logic to keep off the location.

Alongside any write, the unit looks at the masked bits of the value as it was before the change. It reports two flags, all masked bits set and all masked bits clear, which a bit-branch instruction can use. The flags are registered at the edge that ends the operation, are refreshed by every operation, and hold between operations.

The read port returns data in the same cycle as the request. This is the timing of a register file or of a data memory with an asynchronous read.

Top module: `bitop_rmw`

## Requirements
- R1: In each cycle where `op_valid` is high, `rd_req` and `bus_lock` are high in that same cycle. When `op_valid` is low, `rd_req`, `wr_req` and `bus_lock` are all low.
- R2: The test operation (`op_code` = 2'b00) never raises `wr_req`.
- R3: The set operation (`op_code` = 2'b01) raises `wr_req` in the request cycle, with `wr_data` equal to `rd_data | op_mask`.
- R4: The clear operation (`op_code` = 2'b10) raises `wr_req` in the request cycle, with `wr_data` equal to `rd_data & ~op_mask`.
- R5: The invert operation (`op_code` = 2'b11) raises `wr_req` in the request cycle, with `wr_data` equal to `rd_data ^ op_mask`.
- R6: On any write, every bit of `wr_data` whose mask bit is 0 equals the same bit of `rd_data`.
- R7: After the clock edge that ends an operation, `flag_all_set` equals `((rd_data & op_mask) == op_mask)`, computed on the value read before modification, and `flag_valid` is high for exactly that one cycle.
- R8: After the same edge, `flag_all_clr` equals `((rd_data & op_mask) == 0)`, computed on the pre-modification value.
- R9: With an all-zero mask, set, clear and invert write back the word they read unchanged, and both flags are reported as 1.
- R10: After reset, `flag_all_set`, `flag_all_clr` and `flag_valid` are 0. The two flags keep their last value through cycles without an operation.
- R11: Operations on consecutive cycles are each completed and each reported, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Request an operation this cycle |
| op_code | input | 2 | 00 test, 01 set, 10 clear, 11 invert |
| op_mask | input | 16 | Bits of the target that are affected |
| rd_req | output | 1 | Read of the target word |
| rd_data | input | 16 | Target word, returned in the same cycle |
| wr_req | output | 1 | Write of the modified word |
| wr_data | output | 16 | Modified word |
| bus_lock | output | 1 | Location held for the whole read-modify-write |
| flag_all_set | output | 1 | Every masked bit was 1 before modification |
| flag_all_clr | output | 1 | Every masked bit was 0 before modification |
| flag_valid | output | 1 | Flags were updated at the last edge |

## Verification
The bench pays most attention to the zero mask. A design that tests the flags against the unmasked word, or that treats an empty mask as "no match", would report one of the flags as 0 where both must be 1. It also feeds words whose masked bits are mixed. A design that computed the flags from the written value instead of the read value would show an all-set flag right after a set of a partly set word. Test operations are checked for a missing write strobe; a decode that wrote on test would corrupt the target. Back-to-back requests and idle gaps are checked too: a design that cleared the flags when idle, or that dropped every second request, would break the reporting and hold rules.

// File: rtl/bitop_rmw.sv
module bitop_rmw (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [1:0]  op_code,
  input  logic [15:0] op_mask,
  output logic        rd_req,
  input  logic [15:0] rd_data,
  output logic        wr_req,
  output logic [15:0] wr_data,
  output logic        bus_lock,
  output logic        flag_all_set,
  output logic        flag_all_clr,
  output logic        flag_valid
);

  localparam logic [1:0] OP_TEST = 2'b00;
  localparam logic [1:0] OP_SET  = 2'b01;
  localparam logic [1:0] OP_CLR  = 2'b10;
  localparam logic [1:0] OP_INV  = 2'b11;

  logic [15:0] picked;
  logic [15:0] next_word;

  assign picked   = rd_data & op_mask;
  assign rd_req   = op_valid;
  assign bus_lock = op_valid;
  assign wr_req   = op_valid && (op_code != OP_TEST);
  assign wr_data  = next_word;

  always_comb begin
    case (op_code)
      OP_SET:  next_word = rd_data | op_mask;
      OP_CLR:  next_word = rd_data & ~op_mask;
      OP_INV:  next_word = rd_data ^ op_mask;
      default: next_word = rd_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_all_set <= 1'b0;
      flag_all_clr <= 1'b0;
      flag_valid   <= 1'b0;
    end else begin
      flag_valid <= op_valid;
      if (op_valid) begin
        flag_all_set <= (picked == op_mask);
        flag_all_clr <= (picked == 16'h0000);
      end
    end
  end

endmodule

module bitop_rmw_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [1:0]  op_code,
  input logic [15:0] op_mask,
  input logic        rd_req,
  input logic [15:0] rd_data,
  input logic        wr_req,
  input logic [15:0] wr_data,
  input logic        bus_lock,
  input logic        flag_all_set,
  input logic        flag_all_clr,
  input logic        flag_valid
);

  assert_write_inside_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> (rd_req && bus_lock));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !(rd_req || wr_req || bus_lock));

  assert_test_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'b00) |-> !wr_req);

  assert_unmasked_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |-> ((wr_data & ~op_mask) == (rd_data & ~op_mask)));

  assert_flag_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> flag_valid);

  assert_empty_mask_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mask == 16'h0000) |=> (flag_all_set && flag_all_clr));

  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(flag_all_set) && $stable(flag_all_clr)));

  assert_flags_consistent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mask != 16'h0000) |=> !(flag_all_set && flag_all_clr));

endmodule

bind bitop_rmw bitop_rmw_chk u_chk (.*);

// File: tb/bitop_rmw_tb.sv
module bitop_rmw_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_code = 2'b00;
  logic [15:0] op_mask = 16'h0000;
  logic        rd_req;
  logic [15:0] rd_data = 16'h0000;
  logic        wr_req;
  logic [15:0] wr_data;
  logic        bus_lock;
  logic        flag_all_set;
  logic        flag_all_clr;
  logic        flag_valid;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bitop_rmw u_dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [1:0] c, input logic [15:0] w, input logic [15:0] m);
    if (c == 2'b01) return w | m;
    if (c == 2'b10) return w & ~m;
    if (c == 2'b11) return w ^ m;
    return w;
  endfunction

  // present one operation at the falling edge, check the same-cycle bus, then the flags
  task automatic do_op(input string req, input logic [1:0] c, input logic [15:0] m, input logic [15:0] w);
    logic es, ec;
    op_valid = 1'b1; op_code = c; op_mask = m; rd_data = w;
    #1;
    check({req, " rd_req/lock"}, {14'd0, rd_req, bus_lock}, 16'h0003);
    check({req, " wr_req"}, {15'd0, wr_req}, {15'd0, c != 2'b00});
    if (c != 2'b00) check({req, " wr_data"}, wr_data, model(c, w, m));
    es = ((w & m) == m);
    ec = ((w & m) == 16'h0000);
    @(negedge clk);
    check({req, " R7 flag_all_set"}, {15'd0, flag_all_set}, {15'd0, es});
    check({req, " R8 flag_all_clr"}, {15'd0, flag_all_clr}, {15'd0, ec});
    check({req, " R7 flag_valid"}, {15'd0, flag_valid}, 16'h0001);
  endtask

  task automatic go_idle(input string req);
    logic s, c;
    op_valid = 1'b0;
    s = flag_all_set; c = flag_all_clr;
    #1;
    check({req, " idle bus"}, {13'd0, rd_req, wr_req, bus_lock}, 16'h0000);
    @(negedge clk);
    check({req, " flag_valid low"}, {15'd0, flag_valid}, 16'h0000);
    @(negedge clk);
    check({req, " flags held"}, {14'd0, flag_all_set, flag_all_clr}, {14'd0, s, c});
  endtask

  task automatic t_reset;
    check("R10 reset flags", {13'd0, flag_all_set, flag_all_clr, flag_valid}, 16'h0000);
    check("R1 reset idle", {13'd0, rd_req, wr_req, bus_lock}, 16'h0000);
  endtask

  task automatic t_test_op;
    do_op("R2 test partial", 2'b00, 16'h00F0, 16'h0030);
    do_op("R2 test all set", 2'b00, 16'h8001, 16'hFFFF);
    go_idle("R1 after test");
  endtask

  task automatic t_set_clr_inv;
    do_op("R3 set", 2'b01, 16'h0F0F, 16'h1234);
    go_idle("R10 after set");
    do_op("R4 clear", 2'b10, 16'hFF00, 16'hA5A5);
    go_idle("R10 after clear");
    do_op("R5 invert", 2'b11, 16'h5555, 16'hFFFF);
    go_idle("R6 after invert");
  endtask

  task automatic t_conditions;
    do_op("R7 full mask all ones", 2'b10, 16'hFFFF, 16'hFFFF);
    do_op("R8 full mask all zeros", 2'b01, 16'hFFFF, 16'h0000);
    do_op("R7 set on mixed word", 2'b01, 16'h0003, 16'h0001);
    go_idle("R10 after conditions");
  endtask

  task automatic t_zero_mask;
    do_op("R9 set zero mask", 2'b01, 16'h0000, 16'hBEEF);
    do_op("R9 clear zero mask", 2'b10, 16'h0000, 16'h1357);
    do_op("R9 invert zero mask", 2'b11, 16'h0000, 16'hC0DE);
    go_idle("R9 after zero mask");
  endtask

  task automatic t_back_to_back;
    for (int i = 0; i < 8; i++) begin
      logic [15:0] m, w;
      m = 16'h0001 << (i * 2);
      w = (i % 2 == 0) ? m : 16'h0000;
      do_op("R11 back-to-back", 2'(i % 4), m, w);
    end
    go_idle("R11 end");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_test_op();
    t_set_clr_inv();
    t_conditions();
    t_zero_mask();
    t_back_to_back();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule